// File: doc/BRIEF.md
# Power-Up Frequency Strap Latch

This block reads two frequency-select strap pins exactly once, when the system first reports that the processor supply is good. The power-good input is active low and passes through a flop synchronizer. On the clock edge where the synchronized power-good first reads low, the block captures both strap pins. From that point it holds the captured pair until the next power-on reset. A divider network downstream uses the resulting clock-mode code to choose one of three CPU frequencies or one of two test states.

After the capture, the two strap pins become reference-clock outputs, and the block raises a flag that tells the pad logic to drive them. There is one exception. If both straps are captured high, the block enters test clock mode. In this mode the first strap stays an input and selects between a reference-divided clock and high impedance, through a purely combinational path. The second strap is ignored. The captured bits are also presented as a two-bit field for the control register block.

Top module: `fsel_strap_latch`

## Requirements
- R1: After the power-on reset, and before any capture, `mode_o` is 3'd0 (idle), `ref_out_en_o` is 0 and `strap_bits_o` is 2'b00.
- R2: The straps are sampled on the rising edge at which the synchronized power-good first reads low. With the default two-stage synchronizer, this is the third rising edge counted from the first edge that sees `pgood_n_i` low. The outputs are unchanged after the second edge and updated after the third.
- R3: After a capture, no change on `pgood_n_i`, `strap_a_i` or `strap_b_i` alters `strap_bits_o`, and none alters `mode_o` outside test mode, until `por_n_i` is asserted again.
- R4: After a capture with any strap pair other than A=1, B=1, `ref_out_en_o` is 1.
- R5: The captured pair selects the mode code. A=0, B=0 gives `mode_o` = 3'd1 (100 MHz CPU). A=0, B=1 gives 3'd2 (200 MHz CPU). A=1, B=0 gives 3'd3 (133 MHz CPU).
- R6: A captured pair of A=1, B=1 enters test mode. In test mode `ref_out_en_o` stays 0, and `mode_o` follows the live `strap_a_i` with no clock edge needed: 0 gives 3'd4 (reference-divided) and 1 gives 3'd5 (high impedance). `strap_b_i` has no effect.
- R7: Test mode persists through any activity on `pgood_n_i` and on the straps. Only `por_n_i` ends it.
- R8: `strap_bits_o[0]` holds the captured A strap and `strap_bits_o[1]` holds the captured B strap.
- R9: While `pgood_n_i` stays high, strap changes cause no capture: `mode_o` stays 3'd0 and `ref_out_en_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| pgood_n_i | input | 1 | Processor power-good, active low, asynchronous to clk_i |
| strap_a_i | input | 1 | First frequency strap (live value used in test mode) |
| strap_b_i | input | 1 | Second frequency strap |
| strap_bits_o | output | 2 | Captured straps for register readback: bit 0 = A, bit 1 = B |
| mode_o | output | 3 | Clock-mode code for the divider network |
| ref_out_en_o | output | 1 | Turns the strap pins into reference-clock outputs |

## Verification
A capture register that sets too early or too late shows up as a wrong idle-to-mode transition: the port changes one edge earlier or later than the synchronizer depth allows, and the bench checks both neighbouring edges. A capture flag or strap latch that does not hold shows up in the very next cycle after power-good or a strap is wiggled, as a changed `strap_bits_o` or `mode_o`. A wrong test-mode flag, or a test path that is clocked by mistake, is caught immediately after a change on `strap_a_i`, because `mode_o` is sampled before any clock edge occurs.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

   localparam int unsigned MODE_W   = 3;
   localparam int unsigned STRAP_W  = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_IDLE     = 3'd0,
      MODE_CPU100   = 3'd1,
      MODE_CPU200   = 3'd2,
      MODE_CPU133   = 3'd3,
      MODE_TEST_REF = 3'd4,
      MODE_TEST_HIZ = 3'd5
   } fsel_mode_e;

   // strap pair packed as {B, A}
   localparam logic [STRAP_W-1:0] CODE_TEST = 2'b11;

endpackage

// File: rtl/fsel_sync.sv
module fsel_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_n_i) begin
               if (!rst_n_i) chain_q[0] <= RST_VAL;
               else          chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_n_i) begin
               if (!rst_n_i) chain_q[g] <= RST_VAL;
               else          chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/fsel_capture.sv
module fsel_capture
   import fsel_pkg::*;
(
   input  logic               clk_i,
   input  logic               por_n_i,
   input  logic               pg_sync_n_i,
   input  logic               strap_a_i,
   input  logic               strap_b_i,
   output logic               cap_o,
   output logic [STRAP_W-1:0] bits_o
);

   logic               cap_q;
   logic [STRAP_W-1:0] bits_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         cap_q  <= 1'b0;
         bits_q <= '0;
      end else if (!cap_q && !pg_sync_n_i) begin
         cap_q  <= 1'b1;
         bits_q <= {strap_b_i, strap_a_i};
      end
   end

   assign cap_o  = cap_q;
   assign bits_o = bits_q;

   AST_CAPTURE_NEEDS_PG: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(cap_q) |-> $past(!pg_sync_n_i)) else $error("capture without power-good"); // R2
   AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!por_n_i)
      cap_q |=> cap_q) else $error("capture flag cleared"); // R3
   AST_BITS_HELD: assert property (@(posedge clk_i) disable iff (!por_n_i)
      cap_q |=> $stable(bits_q)) else $error("latched straps moved"); // R3
   AST_NO_CAP_PG_HIGH: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!cap_q && pg_sync_n_i) |=> !cap_q) else $error("capture while power-good high"); // R9

endmodule

// File: rtl/fsel_decode.sv
module fsel_decode
   import fsel_pkg::*;
(
   input  logic               cap_i,
   input  logic [STRAP_W-1:0] bits_i,
   input  logic               live_a_i,
   output logic [MODE_W-1:0]  mode_o,
   output logic               ref_en_o
);

   fsel_mode_e mode;
   logic       test;

   assign test = cap_i && (bits_i == CODE_TEST);

   always_comb begin
      mode = MODE_IDLE;
      if (test) begin
         // unclocked: live strap A picks the test output state
         mode = live_a_i ? MODE_TEST_HIZ : MODE_TEST_REF;
      end else if (cap_i) begin
         unique case (bits_i)
            2'b00:   mode = MODE_CPU100;
            2'b10:   mode = MODE_CPU200;
            2'b01:   mode = MODE_CPU133;
            default: mode = MODE_IDLE;
         endcase
      end
   end

   assign mode_o   = mode;
   assign ref_en_o = cap_i && !test;

endmodule

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
   import fsel_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               por_n_i,
   input  logic               pgood_n_i,
   input  logic               strap_a_i,
   input  logic               strap_b_i,
   output logic [STRAP_W-1:0] strap_bits_o,
   output logic [MODE_W-1:0]  mode_o,
   output logic               ref_out_en_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic               pg_sync_n;
   logic               cap;
   logic [STRAP_W-1:0] bits;

   fsel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i   (clk_i),
      .rst_n_i (por_n_i),
      .d_i     (pgood_n_i),
      .q_o     (pg_sync_n)
   );

   fsel_capture u_capture (
      .clk_i       (clk_i),
      .por_n_i     (por_n_i),
      .pg_sync_n_i (pg_sync_n),
      .strap_a_i   (strap_a_i),
      .strap_b_i   (strap_b_i),
      .cap_o       (cap),
      .bits_o      (bits)
   );

   fsel_decode u_decode (
      .cap_i    (cap),
      .bits_i   (bits),
      .live_a_i (strap_a_i),
      .mode_o   (mode_o),
      .ref_en_o (ref_out_en_o)
   );

   assign strap_bits_o = bits;

   AST_REF_ONLY_CPU: assert property (@(posedge clk_i) disable iff (!por_n_i)
      ref_out_en_o |-> (mode_o inside {3'd1, 3'd2, 3'd3})) else $error("ref enable in wrong mode"); // R4
   AST_TEST_STICKY: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (mode_o inside {3'd4, 3'd5}) |=> (mode_o inside {3'd4, 3'd5})) else $error("left test mode"); // R7
   AST_IDLE_NO_REF: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (mode_o == 3'd0) |-> !ref_out_en_o) else $error("ref enable while idle"); // R1

endmodule

// File: tb/fsel_strap_latch_bench.sv
module fsel_strap_latch_bench;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       pgood_n = 1'b1;
   logic       sa = 1'b0;
   logic       sb = 1'b0;
   logic [1:0] bits;
   logic [2:0] mode;
   logic       ref_en;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   fsel_strap_latch u_fsel_strap_latch (
      .clk_i        (clk),
      .por_n_i      (por_n),
      .pgood_n_i    (pgood_n),
      .strap_a_i    (sa),
      .strap_b_i    (sb),
      .strap_bits_o (bits),
      .mode_o       (mode),
      .ref_out_en_o (ref_en)
   );

   // {A, B, mode[2:0], ref_en, bits[1:0]} ; bits = {B, A}
   localparam logic [7:0] VEC [4] = '{
      {1'b0, 1'b0, 3'd1, 1'b1, 2'b00},
      {1'b0, 1'b1, 3'd2, 1'b1, 2'b10},
      {1'b1, 1'b0, 3'd3, 1'b1, 2'b01},
      {1'b1, 1'b1, 3'd5, 1'b0, 2'b11}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      por_n = 1'b0; pgood_n = 1'b1;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 mode", {5'd0, mode}, 8'd0);
      chk("R1 ref_en", {7'd0, ref_en}, 8'd0);
      chk("R1 bits", {6'd0, bits}, 8'd0);

      // R9 straps toggle with power-good high
      for (int i = 0; i < 6; i++) begin
         sa = i[0]; sb = i[1];
         @(negedge clk);
      end
      chk("R9 mode", {5'd0, mode}, 8'd0);
      chk("R9 ref_en", {7'd0, ref_en}, 8'd0);

      for (int v = 0; v < 4; v++) begin
         do_reset();
         sa = VEC[v][7]; sb = VEC[v][6];
         pgood_n = 1'b0;
         repeat (2) @(negedge clk);
         chk("R2 not yet captured", {5'd0, mode}, 8'd0);
         @(negedge clk);
         chk("R5/R6 mode", {5'd0, mode}, {5'd0, VEC[v][5:3]});
         chk("R4/R6 ref_en", {7'd0, ref_en}, {7'd0, VEC[v][2]});
         chk("R8 bits", {6'd0, bits}, {6'd0, VEC[v][1:0]});
         // R3 disturb power-good and B strap after capture
         pgood_n = 1'b1; sb = ~sb;
         repeat (4) @(negedge clk);
         pgood_n = 1'b0;
         repeat (4) @(negedge clk);
         chk("R3 bits held", {6'd0, bits}, {6'd0, VEC[v][1:0]});
         chk("R3 mode held", {5'd0, mode}, {5'd0, VEC[v][5:3]});
         if (v < 3) begin
            sa = ~sa;
            repeat (3) @(negedge clk);
            chk("R3 strap A ignored", {5'd0, mode}, {5'd0, VEC[v][5:3]});
         end
      end

      // R6 asynchronous test path, R7 persistence (still in test mode from last vector)
      @(negedge clk);
      #1 sa = 1'b0;
      #1 chk("R6 async ref-divided", {5'd0, mode}, 8'd4);
      sb = 1'b0;
      #1 chk("R6 strap B ignored", {5'd0, mode}, 8'd4);
      sa = 1'b1;
      #1 chk("R6 async hi-z", {5'd0, mode}, 8'd5);
      chk("R6 ref_en low", {7'd0, ref_en}, 8'd0);
      pgood_n = 1'b1;
      repeat (5) @(negedge clk);
      pgood_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R7 test persists", {6'd0, bits}, 8'd3);
      // R7 power-on reset ends test mode
      por_n = 1'b0;
      #1 chk("R7 por clears", {5'd0, mode}, 8'd0);
      @(negedge clk);
      por_n = 1'b1;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule